// File: doc/BRIEF.md
# Dual-Clock Mirrored Control Register

This block holds one control register as two copies, one in each of two unrelated clock domains, called A and B. Each domain has a small write port made of a strobe, an address and data, and reads its own copy straight from an output. A write that hits the register address updates the local copy on the next local clock edge. The same value is also sent across the clock boundary, so that after a fixed number of far-side clock edges the far copy holds it too.

A crossing moves a whole write at once. The source side latches address and data in a holding register and flips one request bit. Only that bit passes through a flip-flop chain clocked by the destination. The destination sees the flip, samples the stable holding register and returns the flip as an acknowledge through a second chain. Only one write can be in flight per direction. A write made while a crossing is in flight still updates the local copy at once, and its value waits in a one-entry slot that always keeps the newest write.

When a mirrored value and a local write reach one copy in the same cycle, the mirrored value is stored. The local write is then discarded: it is not sent across. Both copies therefore end up with the mirrored value. Each domain has its own synchronous, active-high reset.

Top module: `mirror_ctrl_reg`

## Requirements
- R1: While its domain's reset is high, each copy is cleared to 0 on every rising edge of its own clock.
- R2: A write with strobe high and address 0 loads its data into the local copy on that domain's next rising edge. Address 0 is the only address that selects the register.
- R3: A write with strobe high and an address other than 0 leaves both copies unchanged.
- R4: When no crossing is in flight in that direction, a local write reaches the far copy on the third rising edge of the far clock after the local edge that captured the write, and not before. This holds in both directions.
- R5: Back-to-back local writes made while a crossing is in flight each update the local copy at once, and the far copy ends up holding the last of them.
- R6: If a mirrored value and a local write reach one copy on the same edge, that copy takes the mirrored value and the local write is not forwarded, so both copies end up with the mirrored value.
- R7: When writes from the two sides are spaced further apart than a full round trip, both copies settle to the value of the most recent register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock of domain A |
| rst_a | input | 1 | Synchronous active-high reset, domain A |
| wr_a | input | 1 | Write strobe, domain A |
| addr_a | input | ADDR_W | Write address, domain A |
| wdata_a | input | DATA_W | Write data, domain A |
| q_a | output | DATA_W | Domain A copy of the register |
| clk_b | input | 1 | Clock of domain B |
| rst_b | input | 1 | Synchronous active-high reset, domain B |
| wr_b | input | 1 | Write strobe, domain B |
| addr_b | input | ADDR_W | Write address, domain B |
| wdata_b | input | DATA_W | Write data, domain B |
| q_b | output | DATA_W | Domain B copy of the register |

## Verification
The case that is hardest to produce from the ports is a local write that lands on exactly the edge where a mirrored value arrives. The two clocks have no fixed relationship, so that edge moves from one trial to the next. The clock periods are chosen so their edges never coincide and their phase pattern repeats with a known period. Each collision trial therefore starts at the same point in that pattern and launches a B-side write, while the A-side write is swept across consecutive A-clock offsets. Exactly one offset has to end with both copies holding the B value. Earlier offsets must leave the copies unequal in a known way, and later offsets must let the A value win on both sides.

// File: rtl/mirror_pkg.sv
package mirror_pkg;

    localparam int DEF_DATA_W      = 32;
    localparam int DEF_ADDR_W      = 4;
    localparam int DEF_SYNC_STAGES = 2;

    // state of one crossing lane, seen from its source side
    typedef enum logic {
        LANE_IDLE = 1'b0,
        LANE_BUSY = 1'b1
    } lane_e;

    // which source feeds a copy on the coming edge
    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_LOCAL  = 2'd1,
        UPD_REMOTE = 2'd2
    } upd_e;

    function automatic lane_e lane_of(input logic req_tog, input logic ack_tog);
        return (req_tog == ack_tog) ? LANE_IDLE : LANE_BUSY;
    endfunction

    function automatic logic toggled(input logic now_v, input logic seen_v);
        return now_v ^ seen_v;
    endfunction

endpackage

// File: rtl/mcr_sync_chain.sv
module mcr_sync_chain #(
    parameter int STAGES = mirror_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q_out = stg_q[STAGES-1];

endmodule

// File: rtl/mcr_sender.sv
module mcr_sender
    import mirror_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int PKT_W      = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] fire_addr,
    input  logic [DATA_W-1:0] fire_data,
    input  logic              ack_async,
    output logic              req_tog,
    output logic [PKT_W-1:0]  pkt
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pkt_t;

    pkt_t  hold_q;
    pkt_t  pend_q;
    pkt_t  fire_pkt;
    logic  pend_vld_q;
    logic  req_q;
    logic  ack_sync;
    lane_e lane;

    mcr_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (ack_async),
        .q_out (ack_sync)
    );

    assign lane          = lane_of(req_q, ack_sync);
    assign fire_pkt.addr = fire_addr;
    assign fire_pkt.data = fire_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= 1'b0;
            hold_q     <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (lane == LANE_IDLE) begin
            if (fire) begin
                hold_q     <= fire_pkt;
                req_q      <= ~req_q;
                pend_vld_q <= 1'b0;
            end else if (pend_vld_q) begin
                hold_q     <= pend_q;
                req_q      <= ~req_q;
                pend_vld_q <= 1'b0;
            end
        end else if (fire) begin
            pend_q     <= fire_pkt;
            pend_vld_q <= 1'b1;
        end
    end

    assign req_tog = req_q;
    assign pkt     = hold_q;

    // R5: a new crossing starts only once the previous one is acknowledged
    one_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q != $past(req_q)) |-> ($past(lane) == LANE_IDLE));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (lane == LANE_BUSY) |=> $stable(hold_q));

    // R5
    pend_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_vld_q && lane == LANE_IDLE) |=> (req_q != $past(req_q)));

endmodule

// File: rtl/mcr_receiver.sv
module mcr_receiver
    import mirror_pkg::*;
#(
    parameter int DATA_W                = DEF_DATA_W,
    parameter int ADDR_W                = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int SYNC_STAGES           = DEF_SYNC_STAGES,
    localparam int PKT_W                = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_async,
    input  logic [PKT_W-1:0]  pkt_async,
    output logic              ack_tog,
    output logic              rx_hit,
    output logic [DATA_W-1:0] rx_data
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pkt_t;

    pkt_t pkt_view;
    logic req_sync;
    logic seen_q;
    logic arrive;

    mcr_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (req_async),
        .q_out (req_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= req_sync;
    end

    assign arrive   = toggled(req_sync, seen_q);
    assign pkt_view = pkt_async;
    assign rx_hit   = arrive && (pkt_view.addr == REG_ADDR);
    assign rx_data  = pkt_view.data;
    assign ack_tog  = seen_q;

    // R4: each crossing is taken exactly once
    arrive_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        arrive |=> !arrive);

endmodule

// File: rtl/mcr_side.sv
module mcr_side
    import mirror_pkg::*;
#(
    parameter int DATA_W                = DEF_DATA_W,
    parameter int ADDR_W                = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int SYNC_STAGES           = DEF_SYNC_STAGES,
    localparam int PKT_W                = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic              tx_req,
    output logic [PKT_W-1:0]  tx_pkt,
    input  logic              tx_ack_async,
    input  logic              rx_req_async,
    input  logic [PKT_W-1:0]  rx_pkt_async,
    output logic              rx_ack
);
    logic              local_hit;
    logic              rx_hit;
    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] copy_q;
    logic              fire;
    upd_e              sel;

    assign local_hit = wr && (addr == REG_ADDR);

    always_comb begin
        if (rx_hit)         sel = UPD_REMOTE;
        else if (local_hit) sel = UPD_LOCAL;
        else                sel = UPD_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            copy_q <= '0;
        end else begin
            case (sel)
                UPD_REMOTE: copy_q <= rx_data;
                UPD_LOCAL:  copy_q <= wdata;
                default:    copy_q <= copy_q;
            endcase
        end
    end

    // a local write that loses to a mirrored value is dropped
    assign fire = (sel == UPD_LOCAL);
    assign q    = copy_q;

    mcr_sender #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .fire_addr (addr),
        .fire_data (wdata),
        .ack_async (tx_ack_async),
        .req_tog   (tx_req),
        .pkt       (tx_pkt)
    );

    mcr_receiver #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .REG_ADDR    (REG_ADDR),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk       (clk),
        .rst       (rst),
        .req_async (rx_req_async),
        .pkt_async (rx_pkt_async),
        .ack_tog   (rx_ack),
        .rx_hit    (rx_hit),
        .rx_data   (rx_data)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (copy_q == '0));

    // R6
    remote_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rx_hit |=> (copy_q == $past(rx_data)));

    // R2
    local_take_chk: assert property (@(posedge clk) disable iff (rst)
        (local_hit && !rx_hit) |=> (copy_q == $past(wdata)));

    // R3
    idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!local_hit && !rx_hit) |=> $stable(copy_q));

endmodule

// File: rtl/mirror_ctrl_reg.sv
module mirror_ctrl_reg
    import mirror_pkg::*;
#(
    parameter int DATA_W                = DEF_DATA_W,
    parameter int ADDR_W                = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter int SYNC_STAGES           = DEF_SYNC_STAGES
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              wr_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] q_a,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              wr_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] q_b
);
    localparam int PKT_W = ADDR_W + DATA_W;

    logic             a2b_req;
    logic [PKT_W-1:0] a2b_pkt;
    logic             a2b_ack;
    logic             b2a_req;
    logic [PKT_W-1:0] b2a_pkt;
    logic             b2a_ack;

    mcr_side #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .REG_ADDR    (REG_ADDR),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_side_a (
        .clk          (clk_a),
        .rst          (rst_a),
        .wr           (wr_a),
        .addr         (addr_a),
        .wdata        (wdata_a),
        .q            (q_a),
        .tx_req       (a2b_req),
        .tx_pkt       (a2b_pkt),
        .tx_ack_async (a2b_ack),
        .rx_req_async (b2a_req),
        .rx_pkt_async (b2a_pkt),
        .rx_ack       (b2a_ack)
    );

    mcr_side #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .REG_ADDR    (REG_ADDR),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_side_b (
        .clk          (clk_b),
        .rst          (rst_b),
        .wr           (wr_b),
        .addr         (addr_b),
        .wdata        (wdata_b),
        .q            (q_b),
        .tx_req       (b2a_req),
        .tx_pkt       (b2a_pkt),
        .tx_ack_async (b2a_ack),
        .rx_req_async (a2b_req),
        .rx_pkt_async (a2b_pkt),
        .rx_ack       (a2b_ack)
    );

endmodule

// File: tb/sim_mirror_ctrl_reg.sv
module sim_mirror_ctrl_reg;
    localparam int DW           = 32;
    localparam int AW           = 4;
    localparam int CLK_A_PERIOD = 10;
    localparam int CLK_B_PERIOD = 14;
    localparam int CLK_B_OFFSET = 2;
    localparam int PHASE_LCM    = 70;
    localparam int SWEEP_N      = 7;

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          rst_a, rst_b, wr_a, wr_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [DW-1:0] wdata_a, wdata_b, q_a, q_b;

    int            n_vec = 0;
    int            n_bad = 0;
    logic [DW-1:0] exp_val;
    int            cat [SWEEP_N];

    mirror_ctrl_reg #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk_a(clk_a), .rst_a(rst_a), .wr_a(wr_a), .addr_a(addr_a), .wdata_a(wdata_a), .q_a(q_a),
        .clk_b(clk_b), .rst_b(rst_b), .wr_b(wr_b), .addr_b(addr_b), .wdata_b(wdata_b), .q_b(q_b)
    );

    always #(CLK_A_PERIOD/2) clk_a = ~clk_a;

    initial begin
        #(CLK_B_OFFSET);
        forever begin
            clk_b = 1'b1; #(CLK_B_PERIOD/2);
            clk_b = 1'b0; #(CLK_B_PERIOD/2);
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic check_int(input string tag, input string what, input int act, input int expv);
        n_vec++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic wait_neg(input bit s);
        if (s) @(negedge clk_b); else @(negedge clk_a);
    endtask

    task automatic wait_pos(input bit s);
        if (s) @(posedge clk_b); else @(posedge clk_a);
    endtask

    task automatic set_port(input bit s, input logic w, input logic [AW-1:0] ad, input logic [DW-1:0] d);
        if (s) begin wr_b = w; addr_b = ad; wdata_b = d; end
        else   begin wr_a = w; addr_a = ad; wdata_a = d; end
    endtask

    function automatic logic [DW-1:0] q_of(input bit s);
        return s ? q_b : q_a;
    endfunction

    function automatic logic [DW-1:0] rnd_data();
        return $urandom();
    endfunction

    task automatic settle();
        repeat (40) @(posedge clk_b);
        @(negedge clk_a);
    endtask

    task automatic both_equal(input string tag);
        check(tag, "copy A settled", q_a, exp_val);
        check(tag, "copy B settled", q_b, exp_val);
    endtask

    // single write at any address; address 0 hits the register
    task automatic single_write(input bit s, input logic [AW-1:0] ad, input logic [DW-1:0] d);
        logic [DW-1:0] prev;
        prev = exp_val;
        wait_neg(s);
        set_port(s, 1'b1, ad, d);
        wait_neg(s);
        set_port(s, 1'b0, '0, '0);
        if (ad == '0) begin
            exp_val = d;
            check("R2", "local copy after hit", q_of(s), d);
        end else begin
            check("R3", "local copy after miss", q_of(s), prev);
        end
        settle();
        both_equal(ad == '0 ? "R7" : "R3");
    endtask

    task automatic burst(input bit s, input int n);
        logic [DW-1:0] last;
        last = '0;
        for (int i = 0; i < n; i++) begin
            wait_neg(s);
            if (i > 0) check("R5", "local copy in burst", q_of(s), last);
            last = rnd_data();
            set_port(s, 1'b1, '0, last);
        end
        wait_neg(s);
        check("R5", "local copy end of burst", q_of(s), last);
        set_port(s, 1'b0, '0, '0);
        exp_val = last;
        settle();
        both_equal("R5");
    endtask

    task automatic latency(input bit s);
        logic [DW-1:0] d, prev;
        settle();
        prev = exp_val;
        d = rnd_data();
        wait_neg(s);
        set_port(s, 1'b1, '0, d);
        wait_pos(s);
        fork
            begin
                wait_neg(s);
                set_port(s, 1'b0, '0, '0);
            end
            begin
                repeat (2) wait_pos(!s);
                wait_neg(!s);
                check("R4", "far copy after 2nd far edge", q_of(!s), prev);
                wait_pos(!s);
                wait_neg(!s);
                check("R4", "far copy after 3rd far edge", q_of(!s), d);
            end
        join
        exp_val = d;
        settle();
        both_equal("R4");
    endtask

    task automatic collision_sweep();
        int k, hits;
        for (int d = 0; d < SWEEP_N; d++) begin
            logic [DW-1:0] xa, yb;
            settle();
            xa = rnd_data();
            yb = ~xa;
            do @(posedge clk_a); while (($time % PHASE_LCM) != (CLK_A_PERIOD/2));
            fork
                begin
                    @(negedge clk_b); set_port(1'b1, 1'b1, '0, yb);
                    @(negedge clk_b); set_port(1'b1, 1'b0, '0, '0);
                end
                begin
                    repeat (d) @(posedge clk_a);
                    @(negedge clk_a); set_port(1'b0, 1'b1, '0, xa);
                    @(negedge clk_a); set_port(1'b0, 1'b0, '0, '0);
                end
            join
            settle();
            if (q_a == yb && q_b == xa)      cat[d] = 0;
            else if (q_a == yb && q_b == yb) cat[d] = 1;
            else if (q_a == xa && q_b == xa) cat[d] = 2;
            else                             cat[d] = 3;
            exp_val = q_a;
        end
        k = -1;
        hits = 0;
        for (int d = 0; d < SWEEP_N; d++) begin
            if (cat[d] == 1) begin
                hits++;
                if (k < 0) k = d;
            end
        end
        check_int("R6", "offsets where mirrored value wins both copies", hits, 1);
        if (k >= 0) begin
            for (int d = 0; d < SWEEP_N; d++) begin
                check_int(d > k ? "R7" : "R6", "collision outcome class", cat[d],
                          d < k ? 0 : (d == k ? 1 : 2));
            end
        end
    endtask

    initial begin
        #(1_500_000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        set_port(1'b0, 1'b0, '0, '0);
        set_port(1'b1, 1'b0, '0, '0);
        rst_a = 1'b1;
        rst_b = 1'b1;
        repeat (6) @(posedge clk_b);
        @(negedge clk_a) rst_a = 1'b0;
        @(negedge clk_b) rst_b = 1'b0;
        wait_neg(1'b0);
        check("R1", "copy A after reset", q_a, '0);
        check("R1", "copy B after reset", q_b, '0);
        exp_val = '0;

        latency(1'b0);
        latency(1'b1);
        single_write(1'b0, 4'h3, rnd_data());
        single_write(1'b1, 4'hF, rnd_data());
        single_write(1'b1, 4'h0, rnd_data());
        burst(1'b0, 5);
        burst(1'b1, 4);
        collision_sweep();

        for (int it = 0; it < 120; it++) begin
            bit s;
            int kind;
            s = 1'($urandom() % 2);
            kind = int'($urandom() % 5);
            case (kind)
                0, 1:    single_write(s, '0, rnd_data());
                2:       single_write(s, AW'(1 + ($urandom() % 15)), rnd_data());
                3:       burst(s, 2 + int'($urandom() % 4));
                default: latency(s);
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule